// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This functional unit keeps a small shared file of base registers that many thread processors use as atomic counters. Each thread processor may issue a fetch-and-add request in any cycle. The request selects one base register and carries an increment. The requester receives the value of the base as seen by its own request, and the base is advanced by the increment. A typical use is handing out unique slots in an output array.

All requests that select the same base in the same cycle are merged into one multi-operand prefix computation. The lowest-numbered requester sees the base unchanged, and each higher-numbered requester sees the base plus the increments of all lower-numbered requesters on that base. The base itself takes the full total in a single update, so the requests are not handled one after another. Requests to different bases proceed side by side.

A serial-mode port lets a single controlling processor load and inspect any base register.

Top module: `psu_top`

## Requirements
- R1: After reset every base register reads 0 on `ser_rdata` and every `rsp_valid` bit is low.
- R2: A lone valid request with increment X to base B, which holds V, returns V on its `rsp_value` slice, and B holds V+X afterwards.
- R3: Same-cycle requests to one base are combined in ascending requester index. Requester i receives the base plus the increments of all valid lower-index requesters on that base. The base ends at the original value plus all of those increments.
- R4: Requests that select different bases in the same cycle each combine only with requests to their own base.
- R5: All additions wrap modulo 2^DW (DW=32 by default).
- R6: A request sampled at clock edge k raises its `rsp_valid` bit, with its result, for exactly one cycle after edge k+1. Requests may arrive every cycle, and a request sees the base updates made by the request of the previous cycle.
- R7: A serial write sampled at edge k is visible on `ser_rdata`, for the same `ser_addr`, after edge k+1. The read is combinational from the register file.
- R8: A serial write sampled in the same cycle as requests to the same base is applied first. Those requests combine on top of the written value.
- R9: A requester whose `req_valid` is low gets no `rsp_valid`, and its increment changes no base.
- R10: Requester i's select is `req_sel[i*3 +: 3]`, its increment is `req_inc[i*32 +: 32]`, and its result is `rsp_value[i*32 +: 32]`. These are the default widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Per-requester request strobe |
| req_sel | input | NREQ*SW | Per-requester base register index |
| req_inc | input | NREQ*DW | Per-requester increment |
| rsp_valid | output | NREQ | Per-requester result strobe |
| rsp_value | output | NREQ*DW | Per-requester base value seen |
| ser_wr_en | input | 1 | Serial-mode base write enable |
| ser_addr | input | SW | Serial-mode base index for read and write |
| ser_wdata | input | DW | Serial-mode write data |
| ser_rdata | output | DW | Serial-mode read data |

## Verification
A serial-mode load of a base and prefix-sum requests to that same base can land in the same cycle. The bench provokes this by driving `ser_wr_en` together with requests that select the written base. It then judges the case by checking that the lowest-index requester gets the newly written value and that the final base equals the written value plus the combined increments. A second overlap, two back-to-back request cycles on one base, is judged by the second group's results building on the first group's total.

// File: rtl/psu_pkg.sv
package psu_pkg;
    localparam int PSU_NREQ  = 4;
    localparam int PSU_NBASE = 8;
    localparam int PSU_DW    = 32;
endpackage

// File: rtl/psu_lane.sv
module psu_lane #(
    parameter int NREQ = 4,
    parameter int DW   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DW-1:0]             base_in,
    input  logic                      wr_en,
    input  logic [DW-1:0]             wr_data,
    input  logic [NREQ-1:0]           hit,
    input  logic [NREQ-1:0][DW-1:0]   inc,
    output logic [NREQ-1:0][DW-1:0]   part,
    output logic [DW-1:0]             base_out,
    output logic                      upd
);
    logic [DW-1:0] acc;

    always_comb begin
        acc = wr_en ? wr_data : base_in;
        part = '0;
        for (int i = 0; i < NREQ; i++) begin
            part[i] = acc;
            if (hit[i]) acc = acc + inc[i];
        end
        base_out = acc;
        upd      = wr_en | (|hit);
    end

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && !wr_en) |-> (base_out == base_in));

    // R8
    write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && wr_en) |-> (base_out == wr_data));
endmodule

// File: rtl/psu_top.sv
module psu_top #(
    parameter int NREQ  = psu_pkg::PSU_NREQ,
    parameter int NBASE = psu_pkg::PSU_NBASE,
    parameter int DW    = psu_pkg::PSU_DW,
    localparam int SW   = (NBASE > 1) ? $clog2(NBASE) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NREQ-1:0]      req_valid,
    input  logic [NREQ*SW-1:0]   req_sel,
    input  logic [NREQ*DW-1:0]   req_inc,
    output logic [NREQ-1:0]      rsp_valid,
    output logic [NREQ*DW-1:0]   rsp_value,
    input  logic                 ser_wr_en,
    input  logic [SW-1:0]        ser_addr,
    input  logic [DW-1:0]        ser_wdata,
    output logic [DW-1:0]        ser_rdata
);
    typedef struct packed {
        logic [NREQ-1:0]             s1_v;
        logic [NREQ-1:0][SW-1:0]     s1_sel;
        logic [NREQ-1:0][DW-1:0]     s1_inc;
        logic                        s1_wr;
        logic [SW-1:0]               s1_wa;
        logic [DW-1:0]               s1_wd;
        logic [NBASE-1:0][DW-1:0]    base;
        logic [NREQ-1:0]             rv;
        logic [NREQ-1:0][DW-1:0]     rd;
    } st_t;

    st_t st_d, st_q;

    logic [NBASE-1:0][NREQ-1:0]          hit;
    logic [NBASE-1:0][NREQ-1:0][DW-1:0]  lane_part;
    logic [NBASE-1:0][DW-1:0]            lane_new;
    logic [NBASE-1:0]                    lane_upd;

    for (genvar b = 0; b < NBASE; b++) begin : g_lane
        for (genvar i = 0; i < NREQ; i++) begin : g_hit
            assign hit[b][i] = st_q.s1_v[i] && (st_q.s1_sel[i] == SW'(b));
        end
        psu_lane #(.NREQ(NREQ), .DW(DW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_in  (st_q.base[b]),
            .wr_en    (st_q.s1_wr && (st_q.s1_wa == SW'(b))),
            .wr_data  (st_q.s1_wd),
            .hit      (hit[b]),
            .inc      (st_q.s1_inc),
            .part     (lane_part[b]),
            .base_out (lane_new[b]),
            .upd      (lane_upd[b])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.s1_v   = req_valid;
        st_d.s1_sel = req_sel;
        st_d.s1_inc = req_inc;
        st_d.s1_wr  = ser_wr_en;
        st_d.s1_wa  = ser_addr;
        st_d.s1_wd  = ser_wdata;
        for (int b = 0; b < NBASE; b++) begin
            if (lane_upd[b]) st_d.base[b] = lane_new[b];
        end
        st_d.rv = st_q.s1_v;
        st_d.rd = '0;
        for (int i = 0; i < NREQ; i++) begin
            for (int b = 0; b < NBASE; b++) begin
                if (hit[b][i]) st_d.rd[i] = lane_part[b][i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rv;
    assign rsp_value = st_q.rd;
    assign ser_rdata = st_q.base[ser_addr];

    for (genvar i = 0; i < NREQ; i++) begin : g_chk
        // R6
        rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] |=> ##1 rsp_valid[i]);
        // R9
        no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[i] |=> ##1 !rsp_valid[i]);
    end

    // R9
    base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_v == '0 && !st_q.s1_wr) |=> $stable(st_q.base));
endmodule

// File: tb/tb_psu_top.sv
module tb_psu_top;
    localparam int NREQ = 4;
    localparam int SW   = 3;
    localparam int DW   = 32;

    logic                 clk = 0;
    logic                 rst_n = 0;
    logic [NREQ-1:0]      req_valid = '0;
    logic [NREQ*SW-1:0]   req_sel = '0;
    logic [NREQ*DW-1:0]   req_inc = '0;
    logic [NREQ-1:0]      rsp_valid;
    logic [NREQ*DW-1:0]   rsp_value;
    logic                 ser_wr_en = 0;
    logic [SW-1:0]        ser_addr = '0;
    logic [DW-1:0]        ser_wdata = '0;
    logic [DW-1:0]        ser_rdata;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    logic [DW-1:0] mb [8];
    bit            vv [NREQ];
    int            vsel [NREQ];
    logic [DW-1:0] vinc [NREQ];
    logic [DW-1:0] vexp [NREQ];

    always #4 clk = ~clk;

    psu_top dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_sel(req_sel), .req_inc(req_inc),
        .rsp_valid(rsp_valid), .rsp_value(rsp_value),
        .ser_wr_en(ser_wr_en), .ser_addr(ser_addr),
        .ser_wdata(ser_wdata), .ser_rdata(ser_rdata)
    );

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rdchk(string tag, int a);
        ser_addr = SW'(a);
        #1;
        chk(tag, ser_rdata, mb[a]);
    endtask

    task automatic clear_vec();
        for (int i = 0; i < NREQ; i++) begin
            vv[i] = 0; vsel[i] = 0; vinc[i] = '0;
        end
    endtask

    task automatic drive_vec();
        for (int i = 0; i < NREQ; i++) begin
            req_valid[i]          = vv[i];
            req_sel[i*SW +: SW]   = SW'(vsel[i]);
            req_inc[i*DW +: DW]   = vinc[i];
        end
    endtask

    // expected results per the combining rule: write first, then ascending index
    task automatic model(bit wr, int wa, logic [DW-1:0] wd);
        if (wr) mb[wa] = wd;
        for (int i = 0; i < NREQ; i++) begin
            vexp[i] = '0;
            if (vv[i]) begin
                vexp[i] = mb[vsel[i]];
                mb[vsel[i]] = mb[vsel[i]] + vinc[i];
            end
        end
    endtask

    task automatic check_rsp(string tag);
        for (int i = 0; i < NREQ; i++) begin
            chk({tag, " rsp_valid"}, DW'(rsp_valid[i]), DW'(vv[i]));
            if (vv[i]) chk({tag, " rsp_value"}, rsp_value[i*DW +: DW], vexp[i]);
        end
    endtask

    task automatic fire(string tag, bit wr, int wa, logic [DW-1:0] wd);
        model(wr, wa, wd);
        @(negedge clk);
        drive_vec();
        ser_wr_en = wr; ser_addr = SW'(wa); ser_wdata = wd;
        @(negedge clk);
        req_valid = '0; ser_wr_en = 0;
        chk({tag, " R6 early"}, DW'(rsp_valid), '0);
        @(negedge clk);
        check_rsp(tag);
        for (int i = 0; i < NREQ; i++) if (vv[i]) rdchk({tag, " base"}, vsel[i]);
        if (wr) rdchk({tag, " wbase"}, wa);
    endtask

    task automatic swrite(int a, logic [DW-1:0] d);
        mb[a] = d;
        @(negedge clk);
        ser_wr_en = 1; ser_addr = SW'(a); ser_wdata = d;
        @(negedge clk);
        ser_wr_en = 0;
        @(negedge clk);
        rdchk("R7 serial write/read", a);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", DW'(rsp_valid), '0);
        for (int b = 0; b < 8; b++) rdchk("R1 base", b);
    endtask

    task automatic t_single();
        swrite(2, 32'd100);
        clear_vec();
        vv[1] = 1; vsel[1] = 2; vinc[1] = 32'd5;
        fire("R2 single R10", 0, 0, '0);
        chk("R2 base value", mb[2], 32'd105);
    endtask

    task automatic t_combine();
        swrite(3, 32'd10);
        clear_vec();
        for (int i = 0; i < NREQ; i++) begin
            vv[i] = 1; vsel[i] = 3; vinc[i] = DW'(i + 1);
        end
        fire("R3 combine", 0, 0, '0);
        chk("R3 total", mb[3], 32'd20);
        clear_vec();
        vv[0] = 1; vv[2] = 1; vv[3] = 1;
        vsel[0] = 3; vsel[1] = 3; vsel[2] = 3; vsel[3] = 3;
        vinc[0] = 32'd7; vinc[1] = 32'd1000; vinc[2] = 32'd8; vinc[3] = 32'd9;
        fire("R9 gap", 0, 0, '0);
        chk("R9 total skips idle", mb[3], 32'd44);
    endtask

    task automatic t_indep();
        swrite(4, 32'd1000);
        swrite(5, 32'd2000);
        clear_vec();
        for (int i = 0; i < NREQ; i++) begin
            vv[i] = 1; vsel[i] = (i % 2 == 0) ? 4 : 5; vinc[i] = DW'(10 * (i + 1));
        end
        fire("R4 indep", 0, 0, '0);
    endtask

    task automatic t_wrap();
        swrite(6, 32'hFFFF_FFF0);
        clear_vec();
        vv[0] = 1; vsel[0] = 6; vinc[0] = 32'h10;
        vv[3] = 1; vsel[3] = 6; vinc[3] = 32'h5;
        fire("R5 wrap", 0, 0, '0);
        chk("R5 wrapped base", mb[6], 32'h5);
    endtask

    task automatic t_b2b();
        logic [DW-1:0] e0, e1;
        clear_vec();
        e0 = mb[7];
        e1 = mb[7] + 32'd3;
        mb[7] = mb[7] + 32'd7;
        @(negedge clk);
        req_valid = 4'b0001; req_sel[0 +: SW] = 3'd7; req_inc[0 +: DW] = 32'd3;
        @(negedge clk);
        req_valid = 4'b0100; req_sel[2*SW +: SW] = 3'd7; req_inc[2*DW +: DW] = 32'd4;
        chk("R6 not yet", DW'(rsp_valid), '0);
        @(negedge clk);
        req_valid = '0;
        chk("R6 first valid", DW'(rsp_valid), 32'b0001);
        chk("R6 first value", rsp_value[0 +: DW], e0);
        @(negedge clk);
        chk("R6 second valid", DW'(rsp_valid), 32'b0100);
        chk("R6 second value", rsp_value[2*DW +: DW], e1);
        rdchk("R6 base", 7);
        @(negedge clk);
        chk("R6 one cycle", DW'(rsp_valid), '0);
    endtask

    task automatic t_collide();
        swrite(1, 32'd77);
        clear_vec();
        vv[0] = 1; vsel[0] = 1; vinc[0] = 32'd7;
        vv[2] = 1; vsel[2] = 1; vinc[2] = 32'd2;
        fire("R8 write+req", 1, 1, 32'd500);
        chk("R8 final base", mb[1], 32'd509);
    endtask

    initial begin
        for (int b = 0; b < 8; b++) mb[b] = '0;
        clear_vec();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single();
        t_combine();
        t_indep();
        t_wrap();
        t_b2b();
        t_collide();
        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule